// File: doc/BRIEF.md
# Flash Program/Erase Progress Responder

A device-side model, in synthesizable logic, of a small byte-wide flash array running its internal program and erase algorithms. A host issues byte-program, sector-erase and reset commands on a synchronous command port. Each program or erase keeps the device busy for a fixed number of cycles. The write or the sector erase is applied when that time is up.

While an operation is running, a read returns a progress byte instead of array contents. Bit 7 of that byte is the inverse of bit 7 of the byte being programmed, or 0 inside a sector being erased. Bit 5 flags a failure. Software polls until bit 7 matches the intended data, or until bit 5 rises.

Failures come from three sources:
- An attempt to program a 1 over a stored 0.
- An operation that exceeds its time limit.
- A test input that forces such a time-out.

After a failure the device keeps reporting the failure until a reset command returns it to array reads.

The command port is valid/ready. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. The host holds `cmd_op`, `cmd_addr` and `cmd_data` stable while `cmd_valid` is high and `cmd_ready` is low. The read port has no back-pressure. Every `rd_en` pulse produces one `rd_vld` response one cycle later, and the host must always accept it.

Top module: `flash_status_resp`

## Requirements
- R1: After reset `cmd_ready` is 1, `rd_vld` is 0, and every array byte reads 0xFF.
- R2: A read requested with `rd_en` on one edge returns `rd_data` with `rd_vld` high after the next edge. In read-array mode `rd_data` is the stored byte at `rd_addr`.
- R3: `cmd_op` encodes 2'b01 program, 2'b10 sector erase, 2'b11 reset and 2'b00 no-op. `cmd_ready` is low only while an operation is running, and a command transfers only when `cmd_valid` and `cmd_ready` are both high.
- R4: While a legal program runs, a read at any address returns a progress byte. In that byte, bit 7 is the inverse of bit 7 of the pending data, and all other bits, including bit 5, are 0.
- R5: A legal program with no forced time-out keeps the device busy for exactly PROG_CYC consecutive reads. After that, the addressed byte reads back as the programmed data, so bit 7 matches.
- R6: A program whose data has a 1 where the stored byte has a 0 enters the fault state at once. Reads then return bit 7 inverted from the data and bit 5 set, and the array is not changed.
- R7: While a sector erase runs, a read inside that sector returns 0x00 for exactly ERASE_CYC consecutive reads. A read outside that sector returns the stored byte. A sector is the group of addresses sharing the upper ADDR_W-SECT_W address bits.
- R8: When an erase completes, every byte of the addressed sector reads 0xFF, and bytes of other sectors are unchanged.
- R9: With `force_tmo` held high, an operation never completes. After TMO_CYC busy reads, the progress byte gains bit 5 and keeps the same bit 7, and the array is left unchanged.
- R10: In the fault state `cmd_ready` is high, program and erase commands are taken but have no effect, and reads keep returning the fault byte. A reset command returns the device to read-array mode on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | ADDR_W | Byte address (erase uses the sector part) |
| cmd_data | input | 8 | Program data |
| force_tmo | input | 1 | Test input: suppresses completion so the time limit is hit |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_vld | output | 1 | Read response valid |
| rd_data | output | 8 | Array byte or progress byte |

## Verification
The assertions rely on the host behaving as the port rules above require:
- It keeps a command stable until it is taken.
- It raises `cmd_valid` only with one of the four defined codes.
- It keeps `force_tmo` steady for the whole life of an operation.

The bench's command task drives all command fields together on a falling edge and holds them until the edge that accepts them. The time-out path sets `force_tmo` before the command is issued and clears it only after the fault is seen. Random program data is drawn from the bench's own copy of the array, so a command is illegal only when the bench decides it should be.

// File: rtl/fesr_pkg.sv
package fesr_pkg;
  typedef enum logic [1:0] {
    OP_NOP   = 2'b00,
    OP_PROG  = 2'b01,
    OP_ERASE = 2'b10,
    OP_RESET = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    MODE_READ  = 2'b00,
    MODE_BUSY  = 2'b01,
    MODE_FAULT = 2'b10
  } mode_e;

  // progress byte: bit 7 polling flag, bit 5 failure flag, all others 0
  function automatic logic [7:0] progress_byte(logic is_prog, logic d7, logic fault);
    return {is_prog & ~d7, 1'b0, fault, 5'b00000};
  endfunction
endpackage

// File: rtl/fesr_timer.sv
module fesr_timer #(
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12,
  parameter int TMO_CYC   = 20,
  localparam int CW = $clog2(TMO_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic running,
  input  logic is_erase,
  input  logic force_tmo,
  output logic done,
  output logic timed_out
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  assign lim_m1    = is_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
  assign done      = running && !force_tmo && (cnt == lim_m1);
  assign timed_out = running && !done && (cnt == CW'(TMO_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || start) cnt <= '0;
    else if (running)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/fesr_array.sv
module fesr_array #(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 4,
  localparam int DEPTH = 1 << ADDR_W,
  localparam int TAG_W = ADDR_W - SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              er_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [7:0]        ra_byte,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [7:0]        rb_byte
);
  logic [7:0] cells [DEPTH];

  assign ra_byte = cells[ra_addr];
  assign rb_byte = cells[rb_addr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rst_n) begin
        cells[i] <= 8'hFF;
      end else if (er_en && (ADDR_W'(i) >> SECT_W) == ADDR_W'(wr_addr[ADDR_W-1 -: TAG_W])) begin
        cells[i] <= 8'hFF;
      end else if (wr_en && ADDR_W'(i) == wr_addr) begin
        cells[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/fesr_readout.sv
module fesr_readout
  import fesr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int SECT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_e             mode,
  input  op_e               pend_op,
  input  logic [ADDR_W-1:0] pend_addr,
  input  logic [7:0]        pend_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        arr_byte,
  output logic              rd_vld,
  output logic [7:0]        rd_data
);
  logic same_sector;
  logic show_prog;
  logic [7:0] next_byte;

  assign same_sector = rd_addr[ADDR_W-1:SECT_W] == pend_addr[ADDR_W-1:SECT_W];
  assign show_prog   = (mode != MODE_READ) && (pend_op == OP_PROG || same_sector);
  assign next_byte   = show_prog
                     ? progress_byte(pend_op == OP_PROG, pend_data[7], mode == MODE_FAULT)
                     : arr_byte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_vld  <= 1'b0;
      rd_data <= 8'h00;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= next_byte;
    end
  end
endmodule

// File: rtl/flash_status_resp.sv
module flash_status_resp
  import fesr_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int SECT_W    = 4,
  parameter int PROG_CYC  = 6,
  parameter int ERASE_CYC = 12,
  parameter int TMO_CYC   = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  input  logic              force_tmo,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_vld,
  output logic [7:0]        rd_data
);
  mode_e             mode;
  op_e               pend_op;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0]        pend_data;
  logic [7:0]        chk_byte;
  logic [7:0]        arr_byte;
  logic              cmd_fire;
  logic              illegal;
  logic              start;
  logic              done;
  logic              timed_out;
  op_e               op_in;

  assign op_in     = op_e'(cmd_op);
  assign cmd_ready = (mode != MODE_BUSY);
  assign cmd_fire  = cmd_valid && cmd_ready;
  assign illegal   = |(cmd_data & ~chk_byte);
  assign start     = cmd_fire && (mode == MODE_READ) &&
                     ((op_in == OP_PROG && !illegal) || op_in == OP_ERASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode      <= MODE_READ;
      pend_op   <= OP_NOP;
      pend_addr <= '0;
      pend_data <= 8'h00;
    end else begin
      unique case (mode)
        MODE_READ: begin
          if (cmd_fire && (op_in == OP_PROG || op_in == OP_ERASE)) begin
            pend_op   <= op_in;
            pend_addr <= cmd_addr;
            pend_data <= cmd_data;
            mode      <= (op_in == OP_PROG && illegal) ? MODE_FAULT : MODE_BUSY;
          end
        end
        MODE_BUSY: begin
          if (done)           mode <= MODE_READ;
          else if (timed_out) mode <= MODE_FAULT;
        end
        MODE_FAULT: begin
          if (cmd_fire && op_in == OP_RESET) mode <= MODE_READ;
        end
        default: mode <= MODE_READ;
      endcase
    end
  end

  fesr_timer #(
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .TMO_CYC(TMO_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start),
    .running(mode == MODE_BUSY), .is_erase(pend_op == OP_ERASE),
    .force_tmo(force_tmo), .done(done), .timed_out(timed_out)
  );

  fesr_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_array (
    .clk(clk), .rst_n(rst_n),
    .wr_en(done && pend_op == OP_PROG),
    .er_en(done && pend_op == OP_ERASE),
    .wr_addr(pend_addr), .wr_data(pend_data),
    .ra_addr(cmd_addr), .ra_byte(chk_byte),
    .rb_addr(rd_addr), .rb_byte(arr_byte)
  );

  fesr_readout #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_readout (
    .clk(clk), .rst_n(rst_n), .mode(mode), .pend_op(pend_op),
    .pend_addr(pend_addr), .pend_data(pend_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .arr_byte(arr_byte),
    .rd_vld(rd_vld), .rd_data(rd_data)
  );
endmodule

// File: rtl/fesr_checker.sv
module fesr_checker
  import fesr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [1:0]        cmd_op,
  input logic [7:0]        cmd_data,
  input logic [7:0]        chk_byte,
  input mode_e             mode,
  input op_e               pend_op,
  input logic [7:0]        pend_data,
  input logic              rd_vld,
  input logic [7:0]        rd_data
);
  logic fire;
  assign fire = cmd_valid && cmd_ready;

  AST_ERASE_BLOCKS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_READ && cmd_op == 2'b10) |=> !cmd_ready); // R3

  AST_PROG_POLL_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && $past(mode == MODE_BUSY && pend_op == OP_PROG))
      |-> (rd_data[6] == 1'b0 && rd_data[5] == 1'b0 && rd_data[4:0] == 5'b0)); // R4

  AST_PROG_POLL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_vld && $past(mode == MODE_BUSY && pend_op == OP_PROG))
      |-> (rd_data[7] != $past(pend_data[7]))); // R4

  AST_ILLEGAL_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && mode == MODE_READ && cmd_op == 2'b01 && (cmd_data & ~chk_byte) != 8'h00)
      |=> mode == MODE_FAULT); // R6

  AST_FAULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAULT && !(fire && cmd_op == 2'b11)) |=> mode == MODE_FAULT); // R10

  AST_RESET_EXITS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FAULT && fire && cmd_op == 2'b11) |=> mode == MODE_READ); // R10
endmodule

bind flash_status_resp fesr_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .cmd_data(cmd_data), .chk_byte(chk_byte), .mode(mode),
  .pend_op(pend_op), .pend_data(pend_data), .rd_vld(rd_vld), .rd_data(rd_data)
);

// File: tb/flash_status_resp_bench.sv
module flash_status_resp_bench;
  localparam int AW = 6, SW = 4, PC = 6, EC = 12, TC = 20;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_ready, force_tmo = 1'b0, rd_en = 1'b0, rd_vld;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0, rd_addr = '0;
  logic [7:0] cmd_data = 8'h00, rd_data;
  logic [7:0] bm [DEPTH];
  int checks = 0, fails = 0, cycles = 0;

  always #2 clk = ~clk;

  flash_status_resp #(.ADDR_W(AW), .SECT_W(SW), .PROG_CYC(PC), .ERASE_CYC(EC),
    .TMO_CYC(TC)) u_flash_status_resp (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .force_tmo(force_tmo),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_vld(rd_vld), .rd_data(rd_data));

  function automatic logic [7:0] pbyte(logic prog, logic d7, logic flt);
    return {prog & ~d7, 1'b0, flt, 5'b0};
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      summary();
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [1:0] op, logic [AW-1:0] a, logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk); #1;
    cmd_valid = 1'b0;
  endtask

  task automatic rd1(logic [AW-1:0] a, output logic [7:0] v, output logic vld);
    @(negedge clk); rd_addr = a; rd_en = 1'b1;
    @(posedge clk); #1 rd_en = 1'b0;
    @(negedge clk); v = rd_data; vld = rd_vld;
  endtask

  task automatic rdchk(string req, logic [AW-1:0] a, logic [7:0] exp);
    logic [7:0] v; logic vl;
    rd1(a, v, vl);
    chk(req, {vl, v}, {1'b1, exp});
  endtask

  // call straight after send(); reads on consecutive edges from the one after acceptance
  task automatic poll(logic [AW-1:0] a, logic [7:0] st, int lim, output int n, output logic [7:0] other);
    rd_addr = a; rd_en = 1'b1; n = 0; other = 8'h00;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); @(negedge clk);
      if (rd_data == st && rd_vld) n++;
      else begin other = rd_data; break; end
    end
    rd_en = 1'b0;
  endtask

  task automatic do_prog(logic [AW-1:0] a, logic [7:0] d);
    int n; logic [7:0] o;
    if ((d & ~bm[a]) != 8'h00) begin
      send(2'b01, a, d);
      poll(a, pbyte(1'b1, d[7], 1'b1), 4, n, o);
      chk("R6 fault held", n, 4);
      rdchk("R6 fault read", a ^ 6'h21, pbyte(1'b1, d[7], 1'b1));
      send(2'b11, 0, 0);
      rdchk("R6 array unchanged", a, bm[a]);
    end else begin
      send(2'b01, a, d);
      poll(a, pbyte(1'b1, d[7], 1'b0), 40, n, o);
      chk("R5 busy reads", n, PC);
      chk("R5 R4 readback", o, d);
      bm[a] = d;
    end
  endtask

  task automatic do_erase(logic [AW-1:0] a);
    int n; logic [7:0] o;
    send(2'b10, a, 0);
    poll(a, 8'h00, 40, n, o);
    chk("R7 erase busy reads", n, EC);
    chk("R8 first erased", o, 8'hFF);
    for (int i = 0; i < DEPTH; i++)
      if ((i >> SW) == (a >> SW)) bm[i] = 8'hFF;
  endtask

  initial begin
    int n; logic [7:0] o, v; logic vl;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int i = 0; i < DEPTH; i++) bm[i] = 8'hFF;
    @(negedge clk);
    chk("R1 ready", cmd_ready, 1);
    chk("R1 rd_vld", rd_vld, 0);
    rdchk("R1 R2 erased at reset", 6'd9, 8'hFF);

    do_prog(6'd3, 8'h5A);
    rdchk("R2 read array", 6'd3, 8'h5A);
    do_prog(6'd4, 8'h80);
    do_prog(6'd3, 8'h7F);
    // outside-sector read during erase
    send(2'b10, 6'd20, 0);
    rd1(6'd3, v, vl);
    chk("R7 outside sector", {vl, v}, {1'b1, bm[3]});
    @(negedge clk); chk("R3 ready low busy", cmd_ready, 0);
    repeat (EC + 2) @(posedge clk);
    for (int i = 16; i < 32; i++) bm[i] = 8'hFF;
    rdchk("R8 sector erased", 6'd31, 8'hFF);
    rdchk("R8 other sector kept", 6'd4, 8'h80);
    do_prog(6'd17, 8'h12);
    do_erase(6'd16);
    rdchk("R8 byte cleared", 6'd17, 8'hFF);

    // illegal program
    do_prog(6'd3, 8'hFF);

    // forced time-out
    force_tmo = 1'b1;
    send(2'b01, 6'd40, 8'h3C);
    poll(6'd40, pbyte(1'b1, 1'b0, 1'b0), 40, n, o);
    chk("R9 tmo busy reads", n, TC);
    chk("R9 tmo status", o, pbyte(1'b1, 1'b0, 1'b1));
    force_tmo = 1'b0;
    @(negedge clk); chk("R10 ready in fault", cmd_ready, 1);
    send(2'b10, 6'd40, 0);
    rdchk("R10 erase ignored", 6'd41, pbyte(1'b1, 1'b0, 1'b1));
    send(2'b01, 6'd40, 8'h00);
    rdchk("R10 prog ignored", 6'd40, pbyte(1'b1, 1'b0, 1'b1));
    send(2'b11, 0, 0);
    rdchk("R10 R9 array unchanged", 6'd40, 8'hFF);

    // erase time-out
    force_tmo = 1'b1;
    send(2'b10, 6'd50, 0);
    poll(6'd49, 8'h00, 40, n, o);
    chk("R9 erase tmo reads", n, TC);
    chk("R9 erase tmo status", o, 8'h20);
    force_tmo = 1'b0;
    send(2'b11, 0, 0);

    // random mix
    for (int k = 0; k < 40; k++) begin
      logic [AW-1:0] a; logic [7:0] d; int sel;
      a = AW'($urandom); sel = $urandom_range(0, 9);
      if (sel < 6) begin d = 8'($urandom) & bm[a]; do_prog(a, d); end
      else if (sel < 8) begin d = 8'($urandom) | ~bm[a]; do_prog(a, d); end
      else do_erase(a);
      rdchk("R2 random readback", a, bm[a]);
    end
    send(2'b11, 0, 0);
    rdchk("R10 reset in read mode no effect", 6'd4, bm[4]);
    summary();
  end
endmodule